// File: doc/BRIEF.md
# Boost PFC Start-up and Protection Sequencer

This block is the digital supervisor of a boost power-factor-correction stage. Six comparator decisions reach it as asynchronous single-bit flags: supply above its turn-on level, supply below its lockout level, feedback below the open-loop level, feedback below the under-voltage level, feedback past the soft-start completion level, and feedback above the over-voltage level. Each flag passes through a two-flop synchronizer. A registered state machine then chooses one of four operating states.

The state drives the converter's control outputs. These are a gate enable, a soft-start select that picks the small fixed charging current for the voltage compensation node, a clamp request for the current compensation node, and a standby indication. A duty-reduction request follows the over-voltage flag while the converter is switching. The supply thresholds form a hysteresis band: between the two levels the block holds its current state. Under-voltage protection is armed only in normal operation. After an under-voltage trip, the block waits until the feedback has dropped below the open-loop level and then risen above it again before it restarts.

Top module: `pfc_seq_top`

## Requirements
- R1: Reset puts the block in the off state (state code 0). In this state the gate enable, soft-start select, duty-reduction and standby outputs are low and the clamp request is high.
- R2: From off, the block enters soft start (code 1, gate enable and soft-start select high) only when the supply turn-on flag is high and the open-loop flag is low together. With the turn-on flag low it stays off.
- R3: From off, with the turn-on flag high while the open-loop flag is high, the block enters standby (code 3). In standby the gate enable is low and the standby and clamp outputs are high.
- R4: In soft start, a high completion flag moves the block to normal operation (code 2). There the gate enable is high and the soft-start select is low.
- R5: In soft start or normal operation, a high open-loop flag moves the block to standby. From a standby not caused by under-voltage, the block returns to soft start once the open-loop flag is low.
- R6: A high supply lockout flag forces the off state from every state. While both supply flags are low, the state is held.
- R7: The under-voltage flag moves the block from normal operation to standby. It has no effect during soft start.
- R8: After an under-voltage trip, standby is left for soft start only after the open-loop flag has been seen high and has then gone low.
- R9: Duty reduction equals the synchronized over-voltage flag while the gate is enabled. It does not change the state and does not disable the gate.
- R10: Each flag is synchronized by two flops. A flag change reaches the duty-reduction output after two clock edges and the state after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_on_a | input | 1 | Supply above turn-on level (async) |
| vcc_low_a | input | 1 | Supply below lockout level (async) |
| fb_open_a | input | 1 | Feedback below open-loop level (async) |
| fb_uv_a | input | 1 | Feedback below under-voltage level (async) |
| fb_ss_done_a | input | 1 | Feedback past soft-start completion level (async) |
| fb_ov_a | input | 1 | Feedback above over-voltage level (async) |
| gate_en | output | 1 | Gate driver enable |
| ss_sel | output | 1 | Select limited soft-start charge current |
| icomp_clamp | output | 1 | Clamp current-compensation node |
| duty_trim | output | 1 | Duty-cycle reduction request |
| standby | output | 1 | Standby indication |
| state_o | output | 2 | State: 0 off, 1 soft start, 2 normal, 3 standby |

## Verification
The bench asserts under-voltage during soft start. A design that armed the check too early would drop straight to standby. After an under-voltage trip, it lowers the under-voltage flag while the feedback stays above the open-loop level. A design without the re-arm memory would restart soft start at once and so would keep cycling. It also raises over-voltage in normal operation to catch a design that gates the switch off instead of trimming duty. It sits in the supply hysteresis band to catch a design that treats "not above turn-on" as lockout. Finally, it samples one cycle before and at the expected arrival of a flag change, which exposes a missing or extra synchronizer stage.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2,
        ST_STBY = 2'd3
    } seq_state_e;

    localparam int NUM_FLAGS = 6;

    typedef struct packed {
        logic vcc_on;
        logic vcc_low;
        logic fb_open;
        logic fb_uv;
        logic fb_ss_done;
        logic fb_ov;
    } flag_s;

    typedef struct packed {
        seq_state_e state;
        logic       uv_hold;
    } fsm_reg_s;

endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
    import pfc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  flag_s      flags_i,
    output seq_state_e state_o
);
    fsm_reg_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (flags_i.vcc_low) begin
            nxt_d.state   = ST_OFF;
            nxt_d.uv_hold = 1'b0;
        end else begin
            unique case (cur_q.state)
                ST_OFF: begin
                    if (flags_i.vcc_on)
                        nxt_d.state = flags_i.fb_open ? ST_STBY : ST_SOFT;
                end
                ST_SOFT: begin
                    if (flags_i.fb_open)         nxt_d.state = ST_STBY;
                    else if (flags_i.fb_ss_done) nxt_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (flags_i.fb_open) begin
                        nxt_d.state = ST_STBY;
                    end else if (flags_i.fb_uv) begin
                        nxt_d.state   = ST_STBY;
                        nxt_d.uv_hold = 1'b1;
                    end
                end
                ST_STBY: begin
                    if (cur_q.uv_hold) begin
                        if (flags_i.fb_open) nxt_d.uv_hold = 1'b0;
                    end else if (!flags_i.fb_open) begin
                        nxt_d.state = ST_SOFT;
                    end
                end
                default: nxt_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= ST_OFF;
            cur_q.uv_hold <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o = cur_q.state;

    assert_lockout_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_i.vcc_low |=> cur_q.state == ST_OFF);

    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_SOFT && $past(cur_q.state) == ST_OFF)
            |-> $past(flags_i.vcc_on && !flags_i.fb_open));

    assert_open_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_SOFT || cur_q.state == ST_RUN)
            && flags_i.fb_open && !flags_i.vcc_low) |=> cur_q.state == ST_STBY);

    assert_uv_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_RUN && flags_i.fb_uv && !flags_i.vcc_low)
            |=> cur_q.state == ST_STBY);

    assert_uv_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_STBY && cur_q.uv_hold) |=> cur_q.state != ST_SOFT);
endmodule

// File: rtl/pfc_seq_decode.sv
module pfc_seq_decode
    import pfc_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       ov_i,
    output logic       gate_en,
    output logic       ss_sel,
    output logic       icomp_clamp,
    output logic       duty_trim,
    output logic       standby
);
    logic running;

    always_comb begin
        running     = (state_i == ST_SOFT) || (state_i == ST_RUN);
        gate_en     = running;
        ss_sel      = (state_i == ST_SOFT);
        icomp_clamp = !running;
        standby     = (state_i == ST_STBY);
        duty_trim   = running && ov_i;
    end
endmodule

// File: rtl/pfc_seq_top.sv
module pfc_seq_top
    import pfc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_on_a,
    input  logic       vcc_low_a,
    input  logic       fb_open_a,
    input  logic       fb_uv_a,
    input  logic       fb_ss_done_a,
    input  logic       fb_ov_a,
    output logic       gate_en,
    output logic       ss_sel,
    output logic       icomp_clamp,
    output logic       duty_trim,
    output logic       standby,
    output logic [1:0] state_o
);
    flag_s      raw_flags, sync_flags;
    seq_state_e state;

    always_comb begin
        raw_flags.vcc_on     = vcc_on_a;
        raw_flags.vcc_low    = vcc_low_a;
        raw_flags.fb_open    = fb_open_a;
        raw_flags.fb_uv      = fb_uv_a;
        raw_flags.fb_ss_done = fb_ss_done_a;
        raw_flags.fb_ov      = fb_ov_a;
    end

    pfc_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (sync_flags)
    );

    pfc_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (sync_flags),
        .state_o (state)
    );

    pfc_seq_decode u_dec (
        .state_i     (state),
        .ov_i        (sync_flags.fb_ov),
        .gate_en     (gate_en),
        .ss_sel      (ss_sel),
        .icomp_clamp (icomp_clamp),
        .duty_trim   (duty_trim),
        .standby     (standby)
    );

    assign state_o = state;

    assert_trim_keeps_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_flags.fb_ov && state == ST_RUN && !sync_flags.vcc_low
            && !sync_flags.fb_open && !sync_flags.fb_uv) |=> gate_en);
endmodule

// File: tb/pfc_seq_top_test.sv
module pfc_seq_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_on = 0, vcc_low = 1, fb_open = 1, fb_uv = 0, ss_done = 0, fb_ov = 0;
    logic gate_en, ss_sel, icomp_clamp, duty_trim, standby;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] st;
        logic       trim;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    pfc_seq_top uut (
        .clk(clk), .rst_n(rst_n),
        .vcc_on_a(vcc_on), .vcc_low_a(vcc_low), .fb_open_a(fb_open),
        .fb_uv_a(fb_uv), .fb_ss_done_a(ss_done), .fb_ov_a(fb_ov),
        .gate_en(gate_en), .ss_sel(ss_sel), .icomp_clamp(icomp_clamp),
        .duty_trim(duty_trim), .standby(standby), .state_o(state_o)
    );

    task automatic cmp(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic run;
                e = q.pop_front();
                run = (e.st == 2'd1) || (e.st == 2'd2);
                cmp(e.tag, "state",   state_o,     e.st);
                cmp(e.tag, "gate",    {1'b0, gate_en},     {1'b0, run});
                cmp(e.tag, "ss_sel",  {1'b0, ss_sel},      {1'b0, e.st == 2'd1});
                cmp(e.tag, "clamp",   {1'b0, icomp_clamp}, {1'b0, !run});
                cmp(e.tag, "standby", {1'b0, standby},     {1'b0, e.st == 2'd3});
                cmp(e.tag, "trim",    {1'b0, duty_trim},   {1'b0, e.trim});
            end
        end
    end

    // driver: set flags at a falling edge, wait, push expectation
    task automatic drive(input logic on, input logic low, input logic op, input logic uv,
                         input logic sd, input logic ov, input int waits,
                         input logic [1:0] st, input logic trim, input string tag);
        exp_t e;
        vcc_on = on; vcc_low = low; fb_open = op; fb_uv = uv; ss_done = sd; fb_ov = ov;
        repeat (waits) @(negedge clk);
        e.st = st; e.trim = trim; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        begin exp_t e; e.st = 2'd0; e.trim = 0; e.tag = "R1"; q.push_back(e); end
        rst_n = 1'b1;
        //    on low op uv sd ov
        drive(0, 0, 0, 0, 0, 0, 4, 2'd0, 0, "R2");   // no turn-on flag: stays off
        drive(1, 0, 1, 0, 0, 0, 4, 2'd3, 0, "R3");   // supply up, feedback absent
        drive(1, 0, 0, 0, 0, 0, 4, 2'd1, 0, "R5");   // feedback present: soft start
        drive(1, 0, 0, 1, 0, 0, 4, 2'd1, 0, "R7");   // under-voltage ignored in soft start
        drive(0, 0, 0, 0, 1, 0, 4, 2'd2, 0, "R4");   // completion; also in hysteresis band
        drive(0, 0, 0, 0, 0, 1, 4, 2'd2, 1, "R9");   // over-voltage trims, gate stays
        drive(0, 0, 0, 0, 0, 0, 4, 2'd2, 0, "R6");   // hysteresis band holds normal
        drive(0, 0, 0, 1, 0, 0, 4, 2'd3, 0, "R7");   // under-voltage trip
        drive(0, 0, 0, 0, 0, 0, 6, 2'd3, 0, "R8");   // feedback above open level: no restart
        drive(0, 0, 1, 0, 0, 0, 4, 2'd3, 0, "R8");   // feedback falls below open level
        drive(0, 0, 0, 0, 0, 0, 4, 2'd1, 0, "R8");   // rises again: restart
        drive(0, 0, 0, 0, 1, 0, 4, 2'd2, 0, "R4");
        drive(0, 0, 1, 0, 0, 0, 4, 2'd3, 0, "R5");   // open loop from normal
        drive(1, 0, 0, 0, 0, 0, 4, 2'd1, 0, "R5");
        drive(0, 1, 0, 0, 0, 0, 4, 2'd0, 0, "R6");   // lockout from soft start
        drive(1, 1, 0, 0, 0, 0, 4, 2'd0, 0, "R6");   // lockout wins over turn-on
        // latency: state after three edges, not two
        drive(1, 0, 0, 0, 0, 0, 2, 2'd0, 0, "R10");
        drive(1, 0, 0, 0, 0, 0, 1, 2'd1, 0, "R10");
        // trim latency: after two edges, not one
        drive(1, 0, 0, 0, 0, 1, 1, 2'd1, 0, "R10");
        drive(1, 0, 0, 0, 0, 1, 1, 2'd1, 1, "R10");
        drive(1, 0, 0, 0, 0, 0, 4, 2'd1, 0, "R9");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule